// File: doc/BRIEF.md
# SCL Low-Period Timeout Monitor

This block guards an I2C controller against a bus that has stopped toggling its clock. While the controller is enabled, it counts the I2C bit periods during which the sampled SCL level stays low. Each period is marked by a one-cycle `bit_tick`. When the count reaches a programmable 20-bit limit, a sticky timeout status flag is set. A limit of zero switches the monitor off.

The flag is readable at all times. It reaches the interrupt line only when the per-source enable is high, and it is cleared by pulsing a write-one clear input. The count returns to zero on every rising edge of SCL and whenever monitoring is inactive. Once a timeout has fired, it does not fire again until SCL rises, so one stuck-low episode raises at most one event.

Monitoring is *active* when `ctrl_en` is high and `tout_limit` is nonzero. A four-state machine tracks the line:
- **ST_OFF**: monitoring is inactive and the count is held at zero.
- **ST_HIGH**: SCL is high.
- **ST_LOW**: SCL is low and counting.
- **ST_EXPIRED**: the limit has been reached and counting stops.

Its transitions are:
- *deactivate*: any state goes to ST_OFF when the monitor is inactive.
- *rise*: an SCL rising edge takes any active state to ST_HIGH and zeroes the count.
- *fall*: ST_OFF or ST_HIGH goes to ST_LOW when SCL is low.
- *settle*: an active ST_OFF goes to ST_HIGH when SCL is high.
- *hit*: the counted tick that brings the count up to the limit takes ST_OFF, ST_HIGH or ST_LOW to ST_EXPIRED.
- *hold*: ST_EXPIRED stays where it is until a rise or a deactivate.

Top module: `scl_low_timeout`

## Requirements
- R1: After reset, `tout_status` and `tout_irq` are 0.
- R2: While active, each cycle with `bit_tick`=1 and `scl_in`=0 adds one to the count. The clock edge that samples the tick bringing the count to `tout_limit` sets `tout_status`.
- R3: With `tout_limit`=0 the status is never set, however long SCL stays low.
- R4: When `ctrl_en` is 0 for a cycle, the count returns to zero and no set occurs. After re-enabling, a full `tout_limit` ticks are needed again.
- R5: A rising edge of `scl_in` (1 now, 0 in the previous cycle; the level before the first cycle is taken as 1) returns the count to zero.
- R6: Ticks sampled while `scl_in`=1 are not counted.
- R7: Once set, `tout_status` stays 1 until it is cleared, whatever SCL, `ctrl_en` or the limit do.
- R8: `tout_clr`=1 at a clock edge clears `tout_status` at that edge. The clear has no effect when the flag is already 0.
- R9: When a set and `tout_clr` fall on the same edge, the flag ends up 1.
- R10: After a timeout, further low ticks do not set the flag again until SCL has risen and the limit has been counted again.
- R11: `tout_irq` is the flag gated by `tout_irq_en`, with no added delay. `tout_status` shows the raw flag even while `tout_irq_en`=0.
- R12: The count never wraps. If `tout_limit` is lowered to or below the current count, the next counted tick sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enabled |
| scl_in | input | 1 | Sampled SCL level |
| bit_tick | input | 1 | One-cycle pulse per I2C clock period |
| tout_limit | input | 20 | Timeout limit in I2C periods, 0 disables |
| tout_irq_en | input | 1 | Interrupt enable for the timeout source |
| tout_clr | input | 1 | Write-one clear of the timeout flag |
| tout_status | output | 1 | Raw sticky timeout flag |
| tout_irq | output | 1 | Enabled timeout interrupt |

## Verification
The flag is registered, so a tick, a clear or an enable change seen at edge k shows up in `tout_status` just after edge k. `tout_irq` follows `tout_irq_en` in the same cycle. The bench drives inputs on the falling edge and reads the outputs 2 ns after the rising edge. At that same point it steps a cycle model built from the requirements. The expected value is therefore always the one produced by the edge just sampled.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

    localparam int unsigned TMO_LIMIT_W_DEF = 20;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_HIGH    = 2'd1,
        ST_LOW     = 2'd2,
        ST_EXPIRED = 2'd3
    } tmo_state_e;

endpackage

// File: rtl/tmo_rise_detect.sv
module tmo_rise_detect #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic rise
);

    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= IDLE_LEVEL;
        end else begin
            lvl_q <= lvl_in;
        end
    end

    assign rise = lvl_in & ~lvl_q;

endmodule

// File: rtl/tmo_low_fsm.sv
module tmo_low_fsm
    import tmo_pkg::*;
#(
    parameter int unsigned LIMIT_W = TMO_LIMIT_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               scl_lvl,
    input  logic               scl_rise,
    input  logic               tick,
    input  logic [LIMIT_W-1:0] limit,
    output logic               hit
);

    localparam int unsigned SUM_W = LIMIT_W + 1;

    tmo_state_e         state_q;
    tmo_state_e         state_d;
    logic [LIMIT_W-1:0] cnt_q;
    logic [LIMIT_W-1:0] cnt_d;
    logic [SUM_W-1:0]   cnt_inc;
    logic               count_en;
    logic               reach;

    assign cnt_inc = {1'b0, cnt_q} + SUM_W'(1);
    assign reach   = (cnt_inc >= {1'b0, limit});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF, ST_HIGH, ST_LOW: begin
                    if (hit) begin
                        state_d = ST_EXPIRED;
                    end else if (scl_lvl) begin
                        state_d = ST_HIGH;
                    end else begin
                        state_d = ST_LOW;
                    end
                end
                ST_EXPIRED: begin
                    if (scl_rise) begin
                        state_d = ST_HIGH;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // outputs and counter update
    always_comb begin
        count_en = 1'b0;
        unique case (state_q)
            ST_OFF, ST_HIGH, ST_LOW: count_en = active & tick & ~scl_lvl;
            ST_EXPIRED:              count_en = 1'b0;
            default:                 count_en = 1'b0;
        endcase
        hit = count_en & reach;
        if (!active || scl_rise) begin
            cnt_d = '0;
        end else if (count_en && !reach) begin
            cnt_d = cnt_inc[LIMIT_W-1:0];
        end else begin
            cnt_d = cnt_q;
        end
    end

endmodule

// File: rtl/tmo_sticky_flag.sv
module tmo_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= set | (q & ~clr);
        end
    end

endmodule

// File: rtl/scl_low_timeout.sv
module scl_low_timeout
    import tmo_pkg::*;
#(
    parameter int unsigned LIMIT_W = TMO_LIMIT_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_en,
    input  logic               scl_in,
    input  logic               bit_tick,
    input  logic [LIMIT_W-1:0] tout_limit,
    input  logic               tout_irq_en,
    input  logic               tout_clr,
    output logic               tout_status,
    output logic               tout_irq
);

    logic mon_active;
    logic scl_rise;
    logic tick_hit;

    assign mon_active = ctrl_en & (tout_limit != '0);

    tmo_rise_detect #(
        .IDLE_LEVEL (1'b1)
    ) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (scl_in),
        .rise   (scl_rise)
    );

    tmo_low_fsm #(
        .LIMIT_W (LIMIT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (mon_active),
        .scl_lvl  (scl_in),
        .scl_rise (scl_rise),
        .tick     (bit_tick),
        .limit    (tout_limit),
        .hit      (tick_hit)
    );

    tmo_sticky_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (tick_hit),
        .clr   (tout_clr),
        .q     (tout_status)
    );

    assign tout_irq = tout_status & tout_irq_en;

endmodule

// File: rtl/scl_low_timeout_chk.sv
module scl_low_timeout_chk #(
    parameter int unsigned LIMIT_W = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctrl_en,
    input logic               scl_in,
    input logic               bit_tick,
    input logic [LIMIT_W-1:0] tout_limit,
    input logic               tout_irq_en,
    input logic               tout_clr,
    input logic               tout_status,
    input logic               tout_irq,
    input logic               hit
);

    AST_NO_TICK_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !tout_status) |=> !tout_status); // R2

    AST_ZERO_LIMIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((tout_limit == '0) && !tout_status) |=> !tout_status); // R3

    AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !tout_status) |=> !tout_status); // R4

    AST_HIGH_NOT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in && !tout_status) |=> !tout_status); // R6

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_status && !tout_clr) |=> tout_status); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_clr && !bit_tick) |=> !tout_status); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && tout_clr) |=> tout_status); // R9

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tout_irq |-> tout_status); // R11

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !tout_irq_en |-> !tout_irq); // R11

endmodule

bind scl_low_timeout scl_low_timeout_chk #(
    .LIMIT_W (LIMIT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_en     (ctrl_en),
    .scl_in      (scl_in),
    .bit_tick    (bit_tick),
    .tout_limit  (tout_limit),
    .tout_irq_en (tout_irq_en),
    .tout_clr    (tout_clr),
    .tout_status (tout_status),
    .tout_irq    (tout_irq),
    .hit         (tick_hit)
);

// File: tb/scl_low_timeout_tb.sv
`timescale 1ns/1ps
module scl_low_timeout_tb;

    localparam int unsigned LW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_en = 1'b0;
    logic          scl_in = 1'b1;
    logic          bit_tick = 1'b0;
    logic [LW-1:0] tout_limit = '0;
    logic          tout_irq_en = 1'b0;
    logic          tout_clr = 1'b0;
    logic          tout_status;
    logic          tout_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_cnt = 0;
    bit m_prev = 1'b1;
    bit m_exp = 1'b0;
    bit m_stat = 1'b0;

    always #5 clk = ~clk;

    scl_low_timeout #(.LIMIT_W(LW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_en     (ctrl_en),
        .scl_in      (scl_in),
        .bit_tick    (bit_tick),
        .tout_limit  (tout_limit),
        .tout_irq_en (tout_irq_en),
        .tout_clr    (tout_clr),
        .tout_status (tout_status),
        .tout_irq    (tout_irq)
    );

    function automatic bit model_step(bit scl, bit tick, bit en, int lim, bit clr);
        bit act;
        bit rise;
        bit hit;
        act  = en && (lim != 0);
        rise = scl && !m_prev;
        hit  = 1'b0;
        if (!act || rise) begin
            m_cnt = 0;
            m_exp = 1'b0;
        end else if (!m_exp && tick && !scl) begin
            if (m_cnt + 1 >= lim) begin
                hit   = 1'b1;
                m_exp = 1'b1;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        m_stat = hit | (m_stat & !clr);
        m_prev = scl;
        return m_stat;
    endfunction

    task automatic check_bit(string req, string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // one cycle: drive at the falling edge, sample 2 ns after the rising edge
    task automatic cyc(bit scl, bit tick, bit en, int lim, bit ien, bit clr);
        bit unused;
        @(negedge clk);
        scl_in      = scl;
        bit_tick    = tick;
        ctrl_en     = en;
        tout_limit  = LW'(lim);
        tout_irq_en = ien;
        tout_clr    = clr;
        @(posedge clk);
        #2;
        unused = model_step(scl, tick, en, lim, clr);
    endtask

    task automatic expect_out(string req, bit exp_stat, bit exp_irq);
        check_bit(req, "tout_status", tout_status, exp_stat);
        check_bit(req, "tout_irq", tout_irq, exp_irq);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #2;
        expect_out("R1", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: limit 3, low ticks, flag set on third
        cyc(0, 0, 1, 3, 1, 0);
        cyc(0, 1, 1, 3, 1, 0);
        cyc(0, 1, 1, 3, 1, 0);
        expect_out("R2", 1'b0, 1'b0);
        cyc(0, 1, 1, 3, 1, 0);
        expect_out("R2", 1'b1, 1'b1);
        // R11: mask off, raw flag visible
        cyc(0, 0, 1, 3, 0, 0);
        expect_out("R11", 1'b1, 1'b0);
        // R7: sticky through rise, disable, zero limit
        cyc(1, 0, 1, 3, 1, 0);
        cyc(1, 1, 0, 0, 1, 0);
        cyc(0, 1, 0, 0, 1, 0);
        expect_out("R7", 1'b1, 1'b1);
        // R8: clear, then clear again while 0
        cyc(1, 0, 1, 2, 1, 1);
        expect_out("R8", 1'b0, 1'b0);
        cyc(1, 0, 1, 2, 1, 1);
        expect_out("R8", 1'b0, 1'b0);

        // R10: expire, clear while still low, no re-set
        cyc(0, 1, 1, 2, 1, 0);
        cyc(0, 1, 1, 2, 1, 0);
        expect_out("R10", 1'b1, 1'b1);
        cyc(0, 0, 1, 2, 1, 1);
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 2, 1, 0);
        expect_out("R10", 1'b0, 1'b0);
        cyc(1, 0, 1, 2, 1, 0);
        cyc(0, 1, 1, 2, 1, 0);
        cyc(0, 1, 1, 2, 1, 0);
        expect_out("R10", 1'b1, 1'b1);

        // R9: set and clear together
        cyc(1, 0, 1, 2, 1, 1);
        cyc(0, 1, 1, 2, 1, 0);
        cyc(0, 1, 1, 2, 1, 1);
        expect_out("R9", 1'b1, 1'b1);
        cyc(1, 0, 1, 3, 1, 1);

        // R5: rise resets the count
        cyc(0, 1, 1, 3, 1, 0);
        cyc(0, 1, 1, 3, 1, 0);
        cyc(1, 0, 1, 3, 1, 0);
        cyc(0, 1, 1, 3, 1, 0);
        cyc(0, 1, 1, 3, 1, 0);
        expect_out("R5", 1'b0, 1'b0);
        cyc(0, 1, 1, 3, 1, 0);
        expect_out("R5", 1'b1, 1'b1);
        cyc(1, 0, 1, 2, 1, 1);

        // R6: ticks while high do not count
        for (int i = 0; i < 6; i++) cyc(1, 1, 1, 2, 1, 0);
        expect_out("R6", 1'b0, 1'b0);
        cyc(0, 1, 1, 2, 1, 0);
        expect_out("R6", 1'b0, 1'b0);
        cyc(1, 0, 1, 3, 1, 0);

        // R4: disable resets the count
        cyc(0, 1, 1, 3, 1, 0);
        cyc(0, 1, 1, 3, 1, 0);
        cyc(0, 0, 0, 3, 1, 0);
        cyc(0, 1, 1, 3, 1, 0);
        cyc(0, 1, 1, 3, 1, 0);
        expect_out("R4", 1'b0, 1'b0);
        cyc(0, 1, 1, 3, 1, 0);
        expect_out("R4", 1'b1, 1'b1);
        cyc(1, 0, 1, 0, 1, 1);

        // R3: zero limit never fires
        for (int i = 0; i < 12; i++) cyc(0, 1, 1, 0, 1, 0);
        expect_out("R3", 1'b0, 1'b0);
        cyc(1, 0, 1, 10, 1, 0);

        // R12: limit lowered below the running count
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 10, 1, 0);
        expect_out("R12", 1'b0, 1'b0);
        cyc(0, 1, 1, 3, 1, 0);
        expect_out("R12", 1'b1, 1'b1);
        cyc(1, 0, 1, 3, 1, 1);
        expect_out("R8", 1'b0, 1'b0);

        // constrained random against the model (R2, R5, R7, R8, R11)
        begin
            bit r_scl = 1'b1;
            int r_lim = 3;
            for (int n = 0; n < 4000; n++) begin
                bit r_tick;
                bit r_en;
                bit r_ien;
                bit r_clr;
                if ($urandom_range(5) == 0) r_scl = ~r_scl;
                if ($urandom_range(60) == 0) r_lim = $urandom_range(6);
                r_tick = ($urandom_range(2) == 0);
                r_en   = ($urandom_range(19) != 0);
                r_ien  = $urandom_range(1);
                r_clr  = ($urandom_range(24) == 0);
                cyc(r_scl, r_tick, r_en, r_lim, r_ien, r_clr);
                expect_out("R2_R7_R8_random", m_stat, m_stat & r_ien);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule